// File: doc/BRIEF.md
# Compressed-Set Branch Target Unit

This unit watches the stream of 16-bit halfwords of a compressed instruction set and works out where the unconditional branches in that stream go. It handles two kinds of branch. The first is a single-halfword relative jump. The second is a call split across two halfwords: a leading halfword stores the upper part of the displacement, and a trailing halfword completes it. The trailing halfword comes in two forms. One keeps the current instruction state. The other switches state and forces a word-aligned target.

Each accepted halfword comes with its byte address and a valid strobe. A completed branch produces a registered one-cycle `br_taken` pulse. In the same cycle the unit presents the target address, the return link (for calls) and a flag that says whether the call switches state. A trailing halfword that does not directly follow a leading one produces a one-cycle `br_fault` pulse instead of a branch.

Top module: `cbr_target_unit`

Halfword encoding: bits [15:11] select the kind and bits [10:0] hold the immediate. The codes are 11100 for the short jump, 11110 for the leading (high-part) halfword, 11111 for the same-state call trailer and 11101 for the state-switching call trailer.

## Requirements
- R1: While reset is held and in the cycle after it is released, `br_taken`, `br_fault`, `br_xstate`, `br_target` and `br_link` are all zero.
- R2: A valid halfword with code 11100 gives `br_taken`=1 one cycle later. The target is address + 4 + (sign-extended bits [10:0]) × 2, `br_xstate` is 0 and `br_link` keeps its previous value.
- R3: A valid halfword with code 11110 gives no `br_taken` and no `br_fault`. It stores its address and the value (sign-extended bits [10:0]) shifted left by 12 as the pending high part.
- R4: A code 11111 halfword that directly follows a code 11110 halfword gives `br_taken`=1 and `br_xstate`=0. The target is (address of the leading halfword) + 4 + pending high part + (zero-extended bits [10:0]) × 2.
- R5: A code 11101 halfword with bit 0 clear that directly follows a code 11110 halfword gives `br_taken`=1 and `br_xstate`=1. The target is ((address of the leading halfword) + 4 + pending high part + (bits [10:1]) × 4) with bits [1:0] cleared.
- R6: On a completed call, `br_link` equals the trailer's address + 2 with bit 0 set to 1.
- R7: A code 11111 or 11101 halfword with no pending leading halfword gives `br_fault`=1 and `br_taken`=0. `br_target`, `br_link` and `br_xstate` keep their values.
- R8: Any valid halfword whose code is not 11110, 11111 or 11101 discards a pending leading halfword, so a trailer that follows it faults.
- R9: A code 11101 halfword with bit 0 set faults even when a leading halfword is pending, and it discards that pending state.
- R10: All address sums wrap modulo 2^32.
- R11: Cycles with `hw_valid`=0 produce no pulses and keep the pending leading halfword.
- R12: `br_taken` and `br_fault` each last exactly one cycle per causing halfword, and a new leading halfword replaces an older pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_valid | input | 1 | Halfword strobe |
| hw_data | input | 16 | Fetched halfword |
| hw_addr | input | 32 | Byte address of the halfword |
| br_taken | output | 1 | One-cycle pulse for a completed branch |
| br_fault | output | 1 | One-cycle pulse for an orphan or malformed trailer |
| br_xstate | output | 1 | Last completed branch switches state |
| br_target | output | 32 | Target of the last completed branch |
| br_link | output | 32 | Return link of the last completed call |

## Verification
The assertions assume that `hw_valid` is never unknown and that halfword addresses are even, so the odd link marker always comes from the unit itself. They also assume the inputs are steady around the sampling edge. The stimulus keeps to these rules: every address it drives is even, and it changes inputs only on the falling clock edge. It holds `hw_valid` high across the rising edge only for halfwords it means the unit to accept.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    // Upper five bits of a halfword, classified.
    typedef enum logic [2:0] {
        HK_OTHER  = 3'd0,
        HK_SHORT  = 3'd1,
        HK_HIGH   = 3'd2,
        HK_CALL   = 3'd3,
        HK_XCALL  = 3'd4
    } hw_kind_e;

    localparam int unsigned HW_W   = 16;
    localparam int unsigned IMM_W  = 11;
    localparam int unsigned HI_SHL = 12;

    localparam logic [4:0] CODE_SHORT = 5'b11100;
    localparam logic [4:0] CODE_HIGH  = 5'b11110;
    localparam logic [4:0] CODE_CALL  = 5'b11111;
    localparam logic [4:0] CODE_XCALL = 5'b11101;

endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
    import cbr_pkg::*;
(
    input  logic [HW_W-1:0]  hw,
    output hw_kind_e         kind,
    output logic [IMM_W-1:0] imm,
    output logic             malformed
);

    always_comb begin
        imm       = hw[IMM_W-1:0];
        malformed = 1'b0;
        unique case (hw[HW_W-1:IMM_W])
            CODE_SHORT: kind = HK_SHORT;
            CODE_HIGH:  kind = HK_HIGH;
            CODE_CALL:  kind = HK_CALL;
            CODE_XCALL: begin
                kind      = HK_XCALL;
                malformed = hw[0];
            end
            default:    kind = HK_OTHER;
        endcase
    end

endmodule

// File: rtl/cbr_target_calc.sv
module cbr_target_calc #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] high_part,
    input  logic [AW-1:0] scaled_imm,
    input  logic          word_align,
    output logic [AW-1:0] target
);

    localparam logic [AW-1:0] PC_AHEAD = AW'(4);

    logic [AW-1:0] sum;

    always_comb begin
        sum    = base_addr + PC_AHEAD + high_part + scaled_imm;
        target = word_align ? {sum[AW-1:2], 2'b00} : sum;
    end

endmodule

// File: rtl/cbr_target_unit.sv
module cbr_target_unit
    import cbr_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hw_valid,
    input  logic [15:0]   hw_data,
    input  logic [AW-1:0] hw_addr,
    output logic          br_taken,
    output logic          br_fault,
    output logic          br_xstate,
    output logic [AW-1:0] br_target,
    output logic [AW-1:0] br_link
);

    localparam int unsigned SEXT_W = AW - IMM_W;

    typedef struct packed {
        logic          pend;
        logic [AW-1:0] pend_addr;
        logic [AW-1:0] pend_high;
        logic          taken;
        logic          fault;
        logic          xstate;
        logic [AW-1:0] target;
        logic [AW-1:0] link;
    } unit_state_t;

    unit_state_t st_d, st_q;

    hw_kind_e         kind;
    logic [IMM_W-1:0] imm;
    logic             malformed;

    logic [AW-1:0] calc_base, calc_high, calc_imm, calc_target;
    logic          calc_align;
    logic [AW-1:0] imm_sext, imm_zext;

    cbr_decode u_decode (
        .hw        (hw_data),
        .kind      (kind),
        .imm       (imm),
        .malformed (malformed)
    );

    assign imm_sext = {{SEXT_W{imm[IMM_W-1]}}, imm};
    assign imm_zext = {{SEXT_W{1'b0}}, imm};

    // Operand steering for the shared adder.
    always_comb begin
        calc_base  = st_q.pend_addr;
        calc_high  = st_q.pend_high;
        calc_imm   = imm_zext << 1;
        calc_align = 1'b0;
        unique case (kind)
            HK_SHORT: begin
                calc_base = hw_addr;
                calc_high = '0;
                calc_imm  = imm_sext << 1;
            end
            HK_XCALL: begin
                calc_imm   = {{SEXT_W{1'b0}}, imm[IMM_W-1:1], 1'b0} << 1;
                calc_align = 1'b1;
            end
            default: ;
        endcase
    end

    cbr_target_calc #(.AW(AW)) u_calc (
        .base_addr  (calc_base),
        .high_part  (calc_high),
        .scaled_imm (calc_imm),
        .word_align (calc_align),
        .target     (calc_target)
    );

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        st_d.fault = 1'b0;
        if (hw_valid) begin
            unique case (kind)
                HK_SHORT: begin
                    st_d.pend   = 1'b0;
                    st_d.taken  = 1'b1;
                    st_d.xstate = 1'b0;
                    st_d.target = calc_target;
                end
                HK_HIGH: begin
                    st_d.pend      = 1'b1;
                    st_d.pend_addr = hw_addr;
                    st_d.pend_high = imm_sext << HI_SHL;
                end
                HK_CALL, HK_XCALL: begin
                    st_d.pend = 1'b0;
                    if (!st_q.pend || malformed) begin
                        st_d.fault = 1'b1;
                    end else begin
                        st_d.taken  = 1'b1;
                        st_d.xstate = (kind == HK_XCALL);
                        st_d.target = calc_target;
                        st_d.link   = (hw_addr + AW'(2)) | AW'(1);
                    end
                end
                default: st_d.pend = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign br_taken  = st_q.taken;
    assign br_fault  = st_q.fault;
    assign br_xstate = st_q.xstate;
    assign br_target = st_q.target;
    assign br_link   = st_q.link;

    AST_TAKEN_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> !br_fault); // R7
    AST_FAULT_FROM_TRAILER: assert property (@(posedge clk) disable iff (rst)
        br_fault |-> $past(hw_valid && (kind == HK_CALL || kind == HK_XCALL))); // R7
    AST_XSTATE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (br_taken && br_xstate) |-> (br_target[1:0] == 2'b00)); // R5
    AST_LINK_MARKED: assert property (@(posedge clk) disable iff (rst)
        br_xstate |-> br_link[0]); // R6
    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (rst)
        !br_taken |-> $stable(br_target)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$past(hw_valid) |-> (!br_taken && !br_fault)); // R11

endmodule

// File: tb/test_cbr_target_unit.sv
module test_cbr_target_unit;

    typedef struct packed {
        logic [15:0] hw;
        logic [31:0] addr;
        logic        tk;
        logic        er;
        logic [31:0] tg;
        logic [31:0] lk;
        logic        ex;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{16'hE004, 32'h0000_1000, 1'b1, 1'b0, 32'h0000_100C, 32'h0000_0000, 1'b0, 8'd2},  // R2 forward
        '{16'hE7FF, 32'h0000_2000, 1'b1, 1'b0, 32'h0000_2002, 32'h0000_0000, 1'b0, 8'd2},  // R2 backward
        '{16'hF001, 32'h0000_3000, 1'b0, 1'b0, 32'h0000_2002, 32'h0000_0000, 1'b0, 8'd3},  // R3
        '{16'hF810, 32'h0000_3002, 1'b1, 1'b0, 32'h0000_4024, 32'h0000_3005, 1'b0, 8'd4},  // R4 R6
        '{16'hF7FF, 32'h0000_8002, 1'b0, 1'b0, 32'h0000_4024, 32'h0000_3005, 1'b0, 8'd3},  // R3 negative
        '{16'hE806, 32'h0000_8004, 1'b1, 1'b0, 32'h0000_7010, 32'h0000_8007, 1'b1, 8'd5},  // R5 R6
        '{16'hF810, 32'h0000_9000, 1'b0, 1'b1, 32'h0000_7010, 32'h0000_8007, 1'b1, 8'd7},  // R7
        '{16'hF001, 32'h0000_A000, 1'b0, 1'b0, 32'h0000_7010, 32'h0000_8007, 1'b1, 8'd3},
        '{16'h0000, 32'h0000_A002, 1'b0, 1'b0, 32'h0000_7010, 32'h0000_8007, 1'b1, 8'd8},  // R8
        '{16'hF810, 32'h0000_A004, 1'b0, 1'b1, 32'h0000_7010, 32'h0000_8007, 1'b1, 8'd8},  // R8
        '{16'hF3FF, 32'hFFFF_FFF0, 1'b0, 1'b0, 32'h0000_7010, 32'h0000_8007, 1'b1, 8'd3},
        '{16'hFFFF, 32'hFFFF_FFF2, 1'b1, 1'b0, 32'h003F_FFF2, 32'hFFFF_FFF5, 1'b0, 8'd10}, // R10
        '{16'hF000, 32'h0000_B000, 1'b0, 1'b0, 32'h003F_FFF2, 32'hFFFF_FFF5, 1'b0, 8'd3},
        '{16'hE801, 32'h0000_B002, 1'b0, 1'b1, 32'h003F_FFF2, 32'hFFFF_FFF5, 1'b0, 8'd9},  // R9
        '{16'hF810, 32'h0000_B004, 1'b0, 1'b1, 32'h003F_FFF2, 32'hFFFF_FFF5, 1'b0, 8'd9},  // R9
        '{16'hF001, 32'h0000_C000, 1'b0, 1'b0, 32'h003F_FFF2, 32'hFFFF_FFF5, 1'b0, 8'd12},
        '{16'hF002, 32'h0000_D000, 1'b0, 1'b0, 32'h003F_FFF2, 32'hFFFF_FFF5, 1'b0, 8'd12},
        '{16'hF800, 32'h0000_D002, 1'b1, 1'b0, 32'h0000_F004, 32'h0000_D005, 1'b0, 8'd12}  // R12
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_valid = 1'b0;
    logic [15:0] hw_data = '0;
    logic [31:0] hw_addr = '0;
    logic        br_taken, br_fault, br_xstate;
    logic [31:0] br_target, br_link;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cbr_target_unit i_cbr_target_unit (
        .clk       (clk),
        .rst       (rst),
        .hw_valid  (hw_valid),
        .hw_data   (hw_data),
        .hw_addr   (hw_addr),
        .br_taken  (br_taken),
        .br_fault  (br_fault),
        .br_xstate (br_xstate),
        .br_target (br_target),
        .br_link   (br_link)
    );

    task automatic chk(input string what, input int rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %08h expected %08h", rq, what, act, exp);
        end
    endtask

    task automatic chk_all(input int rq, input logic tk, input logic er,
                           input logic [31:0] tg, input logic [31:0] lk, input logic ex);
        chk("taken",  rq, 32'(br_taken),  32'(tk));
        chk("fault",  rq, 32'(br_fault),  32'(er));
        chk("xstate", rq, 32'(br_xstate), 32'(ex));
        chk("target", rq, br_target, tg);
        chk("link",   rq, br_link,   lk);
    endtask

    // Drive at the falling edge, sample 2 ns after the rising edge.
    task automatic feed(input logic [15:0] hw, input logic [31:0] addr);
        @(negedge clk);
        hw_valid = 1'b1;
        hw_data  = hw;
        hw_addr  = addr;
        @(posedge clk);
        #2;
        hw_valid = 1'b0;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        hw_valid = 1'b0;
        hw_data  = 16'hF810;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, during and one cycle after release
        repeat (3) @(posedge clk);
        #2;
        chk_all(1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        chk_all(1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            feed(VECS[i].hw, VECS[i].addr);
            chk_all(int'(VECS[i].rq), VECS[i].tk, VECS[i].er, VECS[i].tg, VECS[i].lk, VECS[i].ex);
        end

        // R11: idle cycles keep the pending high part and stay quiet
        feed(16'hF000, 32'h0000_0100);
        for (int k = 0; k < 3; k++) begin
            idle_cycle();
            chk_all(11, 1'b0, 1'b0, 32'h0000_F004, 32'h0000_D005, 1'b0);
        end
        feed(16'hF801, 32'h0000_0102);
        chk_all(11, 1'b1, 1'b0, 32'h0000_0106, 32'h0000_0105, 1'b0);

        // R12: the pulse drops after one cycle
        idle_cycle();
        chk_all(12, 1'b0, 1'b0, 32'h0000_0106, 32'h0000_0105, 1'b0);

        // R7: the fault pulse also lasts one cycle
        feed(16'hE806, 32'h0000_0200);
        chk_all(7, 1'b0, 1'b1, 32'h0000_0106, 32'h0000_0105, 1'b0);
        idle_cycle();
        chk_all(12, 1'b0, 1'b0, 32'h0000_0106, 32'h0000_0105, 1'b0);

        // R8: a short jump between prefix and trailer discards the prefix
        feed(16'hF001, 32'h0000_0300);
        feed(16'hE000, 32'h0000_0302);
        chk_all(2, 1'b1, 1'b0, 32'h0000_0306, 32'h0000_0105, 1'b0);
        feed(16'hF800, 32'h0000_0304);
        chk_all(8, 1'b0, 1'b1, 32'h0000_0306, 32'h0000_0105, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule